// File: doc/BRIEF.md
# RGB Color Wheel Sequencer

The sequencer produces a rainbow that keeps cycling, presented as three 8-bit intensities for red, green and blue. A 16-bit position counter moves forward by one each time a tick is accepted. Its upper byte names one of six hue segments and its lower byte is the offset `r` inside that segment. In every segment one component sweeps linearly, either up or down. Of the other two, one sits at full scale and the other at zero.

The colour is held in output registers. A one-cycle `valid` strobe goes out with each new colour, so a downstream PWM driver can load the same value into every one of its channels (sixteen of them in the intended system). The `run` input pauses the walk: while it is low, ticks are discarded and the outputs stay as they are.

Top module: `hue_wheel_seq`

## Requirements
- R1: After reset the position is 0x0000, the outputs read red 0xFF, green 0x00, blue 0x00, and `valid` is 0.
- R2: A tick is accepted only when `tick` and `run` are both high on a rising clock edge. The new colour appears after that same edge, and `valid` is 1 for exactly that one following cycle. `valid` is 0 in every cycle that does not follow an accepted tick.
- R3: Each accepted tick raises the 16-bit position by one. The colour is derived from the updated position: phase = bits 15:8, r = bits 7:0.
- R4: Phase 0 gives (red, green, blue) = (0xFF, r, 0x00). Phase 1 gives (0xFF−r, 0xFF, 0x00).
- R5: Phase 2 gives (0x00, 0xFF, r). Phase 3 gives (0x00, 0xFF−r, 0xFF).
- R6: Phase 4 gives (r, 0x00, 0xFF). Phase 5 gives (0xFF, 0x00, 0xFF−r).
- R7: If an increment would make the phase field 6, the position becomes 0x0000 and the colour for that tick is (0xFF, 0x00, 0x00). A full revolution therefore takes 1536 ticks.
- R8: While `run` is low, `tick` has no effect. The position and all three outputs hold, and `valid` stays 0.
- R9: At all times at least one component is 0xFF and at least one is 0x00. Between two consecutive accepted ticks, at most one component changes value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | When high, allows ticks to advance the wheel |
| tick | input | 1 | Single-cycle advance request |
| red | output | 8 | Red intensity |
| green | output | 8 | Green intensity |
| blue | output | 8 | Blue intensity |
| valid | output | 1 | One-cycle strobe marking a new colour |

## Verification
The bench aims at the segment edges 0x00FF→0x0100, 0x04FF→0x0500 and 0x05FF→0x0000. A design that used the old position, or that swapped a rising and a falling component, would produce a visible jump in one channel at those points. The wrap is checked on its own because a counter that went on to phase 6 would output a colour that does not match phase 0. Ticks arriving while `run` is low must leave the colour and the strobe alone, which catches gating that covers only the counter or only the output registers. A reset in the middle of the walk must restart the walk from red.

// File: rtl/hue_pkg.sv
package hue_pkg;
  localparam int PHASE_COUNT = 6;

  typedef enum logic [2:0] {
    PH_RISE_G = 3'd0,
    PH_FALL_R = 3'd1,
    PH_RISE_B = 3'd2,
    PH_FALL_G = 3'd3,
    PH_RISE_R = 3'd4,
    PH_FALL_B = 3'd5
  } phase_e;
endpackage

// File: rtl/hue_ramp.sv
module hue_ramp
  import hue_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int POS_W = 2 * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_next,
  output logic             wrap
);
  logic [POS_W-1:0] inc;

  assign inc      = pos_q + POS_W'(1);
  assign wrap     = (inc[POS_W-1:CH_W] == CH_W'(PHASE_COUNT));
  assign pos_next = wrap ? '0 : inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (step) pos_q <= pos_next;
  end
endmodule

// File: rtl/hue_mixer.sv
module hue_mixer
  import hue_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int POS_W = 2 * CH_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [CH_W-1:0]  r_o,
  output logic [CH_W-1:0]  g_o,
  output logic [CH_W-1:0]  b_o
);
  localparam logic [CH_W-1:0] FULL = '1;
  localparam logic [CH_W-1:0] NONE = '0;

  logic [CH_W-1:0] seg;
  logic [CH_W-1:0] off;

  function automatic logic [CH_W-1:0] ramp_up(input logic [CH_W-1:0] v);
    return v;
  endfunction

  function automatic logic [CH_W-1:0] ramp_dn(input logic [CH_W-1:0] v);
    return FULL - v;
  endfunction

  assign seg = pos[POS_W-1:CH_W];
  assign off = pos[CH_W-1:0];

  always_comb begin
    r_o = FULL;
    g_o = NONE;
    b_o = NONE;
    case (seg)
      CH_W'(PH_RISE_G): begin r_o = FULL;         g_o = ramp_up(off); b_o = NONE;         end
      CH_W'(PH_FALL_R): begin r_o = ramp_dn(off); g_o = FULL;         b_o = NONE;         end
      CH_W'(PH_RISE_B): begin r_o = NONE;         g_o = FULL;         b_o = ramp_up(off); end
      CH_W'(PH_FALL_G): begin r_o = NONE;         g_o = ramp_dn(off); b_o = FULL;         end
      CH_W'(PH_RISE_R): begin r_o = ramp_up(off); g_o = NONE;         b_o = FULL;         end
      CH_W'(PH_FALL_B): begin r_o = FULL;         g_o = NONE;         b_o = ramp_dn(off); end
      default:          begin r_o = FULL;         g_o = NONE;         b_o = NONE;         end
    endcase
  end
endmodule

// File: rtl/hue_out_reg.sv
module hue_out_reg #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] r_d,
  input  logic [CH_W-1:0] g_d,
  input  logic [CH_W-1:0] b_d,
  output logic [CH_W-1:0] r_q,
  output logic [CH_W-1:0] g_q,
  output logic [CH_W-1:0] b_q,
  output logic            strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q    <= '1;
      g_q    <= '0;
      b_q    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= load;
      if (load) begin
        r_q <= r_d;
        g_q <= g_d;
        b_q <= b_d;
      end
    end
  end
endmodule

// File: rtl/hue_wheel_seq.sv
module hue_wheel_seq #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  output logic [CH_W-1:0] red,
  output logic [CH_W-1:0] green,
  output logic [CH_W-1:0] blue,
  output logic            valid
);
  localparam int POS_W = 2 * CH_W;

  logic             accept;
  logic             wrap;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_next;
  logic [CH_W-1:0]  mix_r;
  logic [CH_W-1:0]  mix_g;
  logic [CH_W-1:0]  mix_b;

  assign accept = run & tick;

  hue_ramp #(.CH_W(CH_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (accept),
    .pos_q    (pos_q),
    .pos_next (pos_next),
    .wrap     (wrap)
  );

  hue_mixer #(.CH_W(CH_W)) u_mix (
    .pos (pos_next),
    .r_o (mix_r),
    .g_o (mix_g),
    .b_o (mix_b)
  );

  hue_out_reg #(.CH_W(CH_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .r_d    (mix_r),
    .g_d    (mix_g),
    .b_d    (mix_b),
    .r_q    (red),
    .g_q    (green),
    .b_q    (blue),
    .strobe (valid)
  );
endmodule

// File: rtl/hue_wheel_chk.sv
module hue_wheel_chk
  import hue_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int POS_W = 2 * CH_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             wrap,
  input logic [POS_W-1:0] pos_q,
  input logic [CH_W-1:0]  red,
  input logic [CH_W-1:0]  green,
  input logic [CH_W-1:0]  blue,
  input logic             valid
);
  localparam logic [CH_W-1:0] FULL = '1;

  p_strobe_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> valid);

  p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !valid);

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wrap) |=> (pos_q == $past(pos_q) + POS_W'(1)));

  p_phase_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q[POS_W-1:CH_W] < CH_W'(PHASE_COUNT));

  p_wrap_to_red_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wrap) |=> (pos_q == '0 && red == FULL && green == '0 && blue == '0));

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(red) && $stable(green) && $stable(blue) && $stable(pos_q)));

  p_extremes_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (red == FULL || green == FULL || blue == FULL) && (red == '0 || green == '0 || blue == '0));

  p_single_mover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones({red != $past(red), green != $past(green), blue != $past(blue)}) <= 1));
endmodule

bind hue_wheel_seq hue_wheel_chk #(.CH_W(CH_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .accept (accept),
  .wrap   (wrap),
  .pos_q  (pos_q),
  .red    (red),
  .green  (green),
  .blue   (blue),
  .valid  (valid)
);

// File: tb/sim_hue_wheel_seq.sv
module sim_hue_wheel_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] red, green, blue;
  logic       valid;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  hue_wheel_seq u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .red(red), .green(green), .blue(blue), .valid(valid)
  );

  always #10 clk = ~clk;

  // advance count, expected colour after those ticks {r,g,b}
  localparam logic [39:0] VEC [15] = '{
    {16'h0001, 24'hFF_01_00},   // R4
    {16'h007F, 24'hFF_80_00},   // R4
    {16'h007F, 24'hFF_FF_00},   // R4
    {16'h0001, 24'hFF_FF_00},   // R4 phase 1 r=0
    {16'h0040, 24'hBF_FF_00},   // R4
    {16'h00C0, 24'h00_FF_00},   // R5
    {16'h0010, 24'h00_FF_10},   // R5
    {16'h0100, 24'h00_EF_FF},   // R5
    {16'h0100, 24'h10_00_FF},   // R6
    {16'h00EF, 24'hFF_00_FF},   // R6
    {16'h0001, 24'hFF_00_FF},   // R6
    {16'h00FE, 24'hFF_00_01},   // R6
    {16'h0001, 24'hFF_00_00},   // R6
    {16'h0001, 24'hFF_00_00},   // R7 wrap
    {16'h0001, 24'hFF_01_00}    // R7 after wrap
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic one_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // independent model: each component as a function of the ramp position
  function automatic logic [23:0] model(input int pos);
    int seg = pos / 256;
    int r   = pos % 256;
    int cr, cg, cb;
    cr = (seg == 0 || seg == 5) ? 255 : (seg == 1) ? 255 - r : (seg == 4) ? r : 0;
    cg = (seg == 1 || seg == 2) ? 255 : (seg == 0) ? r : (seg == 3) ? 255 - r : 0;
    cb = (seg == 3 || seg == 4) ? 255 : (seg == 2) ? r : (seg == 5) ? 255 - r : 0;
    return {cr[7:0], cg[7:0], cb[7:0]};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset colour", {red, green, blue}, 24'hFF_00_00);
    check("R1 reset valid", {23'd0, valid}, 24'd0);
    rst_n = 1'b1;
    run   = 1'b1;

    for (int i = 0; i < 15; i++) begin
      for (int k = 0; k < int'(VEC[i][39:24]); k++) one_tick();
      check($sformatf("R4-6 table row %0d", i), {red, green, blue}, VEC[i][23:0]);
      check("R2 valid after tick", {23'd0, valid}, 24'd1);
    end
    @(negedge clk);
    check("R2 valid one cycle", {23'd0, valid}, 24'd0);

    // R8: ticks while paused
    run = 1'b0;
    for (int k = 0; k < 5; k++) begin
      one_tick();
      check("R8 hold colour", {red, green, blue}, 24'hFF_01_00);
      check("R8 no valid", {23'd0, valid}, 24'd0);
    end
    run = 1'b1;
    one_tick();
    check("R8 resume step", {red, green, blue}, 24'hFF_02_00);

    // R2: run without tick
    repeat (3) @(negedge clk);
    check("R2 idle no valid", {23'd0, valid}, 24'd0);
    check("R2 idle hold", {red, green, blue}, 24'hFF_02_00);

    // R1: reset mid-stream
    for (int k = 0; k < 300; k++) one_tick();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset colour", {red, green, blue}, 24'hFF_00_00);
    rst_n = 1'b1;
    one_tick();
    check("R1 restart from zero", {red, green, blue}, 24'hFF_01_00);

    // R3 R7 R9: full revolution against the model
    prev = {red, green, blue};
    for (int k = 2; k <= 1538; k++) begin
      one_tick();
      check($sformatf("R3 sweep pos %0d", k % 1536), {red, green, blue}, model(k % 1536));
      n_run++;
      if ((red != prev[23:16]) + (green != prev[15:8]) + (blue != prev[7:0]) > 1) begin
        n_fail++;
        $display("FAIL R9 step %0d: got %06h expected one change from %06h", k, {red, green, blue}, prev);
      end
      prev = {red, green, blue};
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule